// File: doc/BRIEF.md
# GPIO Port Data Register Bank

This block holds the output data of a 32-pin general-purpose I/O port and reports the level of the port's input pins. It sits behind a plain register read/write port: a word address, write data, a write strobe and a combinational read-data bus. The output latch drives the output-data lines directly.

Software can load the whole latch at once. It can also use three alias words that change only the bits written as one: one alias sets them, one clears them and one inverts them. A single pin can therefore change without a read-modify-write sequence.

Input pins pass through a two-stage synchronizer before they reach the read bus. Direction control, output enables, pad configuration and interrupts are handled elsewhere. The register port is a simple strobe interface with no back-pressure: every access completes in its own cycle, so there is no valid/ready pair.

Top module: `gpio_data_bank`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `pin_out` is all zeros.
- R2: A write to word 0 (data) loads `wr_data` into the latch. `pin_out` shows the new value after the next rising edge, and reading word 0 returns the latch value.
- R3: A write to word 1 (set) forces to one every latch bit whose `wr_data` bit is one and leaves all other bits unchanged.
- R4: A write to word 2 (clear) forces to zero every latch bit whose `wr_data` bit is one and leaves all other bits unchanged.
- R5: A write to word 3 (toggle) inverts every latch bit whose `wr_data` bit is one and leaves all other bits unchanged.
- R6: Reading words 1, 2 or 3 returns zero.
- R7: Reading word 4 (pins) returns `pin_in` as sampled two rising edges earlier. A pin change is therefore not visible after one edge, and is visible after two.
- R8: Words 5 to 7 are unmapped. They read as zero, and writes to them leave `pin_out` unchanged.
- R9: While `wr_en` is low, `pin_out` keeps its value whatever `addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Word address of the access |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| wr_data | input | 32 | Write data, one bit per pin |
| rd_data | output | 32 | Read data for the word at `addr` (combinational) |
| pin_in | input | 32 | Asynchronous input pin levels |
| pin_out | output | 32 | Output data latch |

## Verification
The hardest case to reach from the ports is the exact latency of the pin synchronizer. A pin change has to be caught after one edge, when it must still be hidden, and after two edges, when it must show. To reach it, the bench changes `pin_in` at a falling edge and reads word 4 at each of the next falling edges. It also sweeps every address with a series of arithmetic data patterns, with the strobe both high and low, against a bench model of the latch.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned IDX_DATA = 0;
  localparam int unsigned IDX_SET  = 1;
  localparam int unsigned IDX_CLR  = 2;
  localparam int unsigned IDX_TGL  = 3;
  localparam int unsigned IDX_PIN  = 4;

  typedef enum logic [1:0] {
    OP_LOAD, OP_SET, OP_CLR, OP_TGL
  } latch_op_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] async_in,
  output logic [NPINS-1:0] sync_out
);
  logic [NPINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  latch_op_e        op,
  input  logic [NPINS-1:0] mask,
  output logic [NPINS-1:0] q
);
  logic [NPINS-1:0] nxt;

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = mask;
      OP_SET:  nxt = q | mask;
      OP_CLR:  nxt = q & ~mask;
      OP_TGL:  nxt = q ^ mask;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (upd) q <= nxt;
  end
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NPINS-1:0]  latch_q,
  input  logic [NPINS-1:0]  pins_sync,
  output logic              upd,
  output latch_op_e         op,
  output logic [NPINS-1:0]  rd_data
);
  always_comb begin
    upd = 1'b0;
    op  = OP_LOAD;
    if (addr == ADDR_W'(IDX_DATA)) begin
      upd = wr_en;
      op  = OP_LOAD;
    end else if (addr == ADDR_W'(IDX_SET)) begin
      upd = wr_en;
      op  = OP_SET;
    end else if (addr == ADDR_W'(IDX_CLR)) begin
      upd = wr_en;
      op  = OP_CLR;
    end else if (addr == ADDR_W'(IDX_TGL)) begin
      upd = wr_en;
      op  = OP_TGL;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(IDX_DATA))     rd_data = latch_q;
    else if (addr == ADDR_W'(IDX_PIN)) rd_data = pins_sync;
  end
endmodule

// File: rtl/gpio_data_bank.sv
module gpio_data_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out
);
  localparam int unsigned SYNC_STAGES = 2;

  logic             upd;
  latch_op_e        op;
  logic [NPINS-1:0] pins_sync;

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pins_sync)
  );

  gpio_addr_dec #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .latch_q(pin_out), .pins_sync(pins_sync),
    .upd(upd), .op(op), .rd_data(rd_data)
  );

  gpio_out_latch #(.NPINS(NPINS)) u_latch (
    .clk(clk), .rst(rst), .upd(upd), .op(op), .mask(wr_data), .q(pin_out)
  );
endmodule

// File: rtl/gpio_data_bank_chk.sv
module gpio_data_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [NPINS-1:0]  wr_data,
  input logic [NPINS-1:0]  rd_data,
  input logic [NPINS-1:0]  pin_in,
  input logic [NPINS-1:0]  pin_out
);
  logic [1:0] live_cnt;
  logic       mapped_wr;

  always_ff @(posedge clk) begin
    if (rst) live_cnt <= '0;
    else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
  end

  assign mapped_wr = wr_en && (addr <= ADDR_W'(IDX_TGL));

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> pin_out == '0); // R1
  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(IDX_DATA)) |=> pin_out == $past(wr_data)); // R2
  AST_SET_BITS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(IDX_SET)) |=> pin_out == ($past(pin_out) | $past(wr_data))); // R3
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(IDX_CLR)) |=> pin_out == ($past(pin_out) & ~$past(wr_data))); // R4
  AST_TGL_BITS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(IDX_TGL)) |=> pin_out == ($past(pin_out) ^ $past(wr_data))); // R5
  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr >= ADDR_W'(IDX_SET) && addr <= ADDR_W'(IDX_TGL)) |-> rd_data == '0); // R6
  AST_PIN_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (live_cnt == 2'd2 && addr == ADDR_W'(IDX_PIN)) |-> rd_data == $past(pin_in, 2)); // R7
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr > ADDR_W'(IDX_PIN)) |-> rd_data == '0); // R8
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !mapped_wr |=> $stable(pin_out)); // R9
endmodule

bind gpio_data_bank gpio_data_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out)
);

// File: tb/gpio_data_bank_tb.sv
module gpio_data_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] model = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_data_bank u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(int a);
    case (a)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic do_write(int a, logic [31:0] d);
    @(negedge clk);
    addr = 3'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      0: model = d;
      1: model = model | d;
      2: model = model & ~d;
      3: model = model ^ d;
      default: ;
    endcase
    check(req_of(a), pin_out, model);
  endtask

  task automatic do_read(int a, logic [31:0] exp, string req);
    addr = 3'(a);
    #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", pin_out, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", pin_out, 32'h0);

    // Sweep of every word address with arithmetic data patterns
    for (int p = 0; p < 10; p++) begin
      logic [31:0] pat;
      pat = (32'h9E37_79B9 * (p + 1)) ^ (32'h1 << p);
      for (int a = 0; a < 8; a++) begin
        do_write(a, pat ^ (32'h0101_0101 * a));
        do_read(0, model, "R2");
        for (int r = 1; r < 4; r++) do_read(r, 32'h0, "R6");
        for (int r = 5; r < 8; r++) do_read(r, 32'h0, "R8");
      end
    end

    // Strobe low: latch holds for every address (R9)
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      addr = 3'(a); wr_data = ~model ^ (32'h3 << a); wr_en = 1'b0;
      @(negedge clk);
      check("R9", pin_out, model);
    end

    // Single-bit set/clear/toggle corners
    do_write(0, 32'h0);
    do_write(1, 32'h8000_0000);
    do_write(3, 32'h0000_0001);
    do_write(2, 32'h8000_0000);
    do_write(3, 32'hFFFF_FFFF);
    do_write(1, 32'h0);

    // Input synchronizer latency (R7)
    for (int k = 0; k < 6; k++) begin
      logic [31:0] oldv, newv;
      oldv = pin_in;
      newv = 32'hC3A5_0000 + 32'(k * 32'h1111_1111) + 32'(k);
      @(negedge clk);
      wr_en = 1'b0;
      pin_in = newv;
      do_read(4, oldv, "R7");
      @(negedge clk);
      do_read(4, oldv, "R7");
      @(negedge clk);
      do_read(4, newv, "R7");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule